// File: doc/BRIEF.md
# Parallel Host Bus Slave

This block lets an external microcontroller read and write bytes in a small internal register file over a parallel bus. A strap input chooses the bus flavour. In multiplexed mode, the address travels on the shared data lines and is marked by a latch-enable pulse. In separate-bus mode, the address comes from a dedicated 8-bit address input. Every host input is sampled on the core clock, so the host strobes must already be synchronous to it.

Each access runs through a small state machine. The states are:

- `ST_IDLE`: no access is running.
- `ST_WR_WAIT`: a write has started and the internal access is busy.
- `ST_WR_HOLD`: the write access is complete and the block waits for the strobe to be released.
- `ST_RD_WAIT`: a read has started and the internal access is busy.
- `ST_RD_DRIVE`: read data is presented on the bus.

The transitions are:

- start-write: from `ST_IDLE` to `ST_WR_WAIT`. This transition has priority over start-read.
- start-read: from `ST_IDLE` to `ST_RD_WAIT`.
- access-done: from a wait state to `ST_WR_HOLD` or `ST_RD_DRIVE`, when the access counter expires.
- release: from any other state back to `ST_IDLE`, when the active strobe or chip select deasserts.

While a wait state is active, the ready output is driven low, which stretches the host cycle. After that, ready is released to high impedance. The data bus and the ready pin are each modelled as a value plus an output enable.

Top module: `hbus_slave`

## Requirements
- R1: After reset, `data_oe` and `rdy_oe` are 0 and every register reads back as 0x00.
- R2: While `cs_n` is 1, the write strobe, the read strobe and the latch enable are ignored. Nothing is written, `data_oe` stays 0 and `rdy_oe` stays 0.
- R3: With `mux_mode`=1, a cycle with `cs_n`=0 and `ale`=1 loads the address from `data_in`. That address is held after `ale` falls. If `ale`=1 in the same cycle that a strobe is first seen, that cycle's `data_in` is the access address.
- R4: With `mux_mode`=0, the access address is `addr_in` as sampled in the cycle the strobe is first seen, and `ale` has no effect.
- R5: The write data is the last `data_in` value seen while the write strobe was active. It is committed when the write strobe or chip select is released. Only address bits [3:0] select the register, so addresses alias modulo 16.
- R6: `data_oe` is 1 from the cycle after the read strobe is first seen until the cycle after it is released. Once ready is released, `data_out` holds the addressed register.
- R7: When a strobe is held, `rdy_oe`=1 with `rdy_o`=0 for exactly `ACC_CYCLES` cycles, starting in the cycle after the strobe is first seen. After that, `rdy_oe` is 0.
- R8: If the write and read strobes are both active in `ST_IDLE`, the write is performed and `data_oe` stays 0.
- R9: A read strobe released while ready is still low returns the block to idle. In the following cycle, `rdy_oe` and `data_oe` are both 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mux_mode | input | 1 | Bus strap: 1 = multiplexed, 0 = separate buses |
| cs_n | input | 1 | Active-low chip select |
| ale | input | 1 | Address latch enable (multiplexed mode) |
| wr_n | input | 1 | Active-low write strobe |
| rd_n | input | 1 | Active-low read strobe |
| addr_in | input | 8 | Dedicated address bus (separate mode) |
| data_in | input | 8 | Data bus input side (also the address in multiplexed mode) |
| data_out | output | 8 | Data bus output value |
| data_oe | output | 1 | Data bus output enable |
| rdy_o | output | 1 | Ready pin value (always low when driven) |
| rdy_oe | output | 1 | Ready pin enable; 1 while an access is in progress |

## Verification
Two functions can fall in the same clock cycle: the address latch pulse and the start of an access. The bench provokes this by raising `ale` and dropping the write strobe on the same edge, with the shared lines carrying a fresh address while an older address is still held in the latch. The outcome is judged by reading back both locations: the fresh address must hold the new data and the old one must be untouched. A second collision drops both strobes together, and the bench expects a committed write with no data drive.

// File: rtl/hbus_pkg.sv
package hbus_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WR_WAIT,
        ST_WR_HOLD,
        ST_RD_WAIT,
        ST_RD_DRIVE
    } hb_state_t;

endpackage

// File: rtl/hbus_addr_latch.sv
module hbus_addr_latch #(
    parameter int AW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cs_n,
    input  logic          ale,
    input  logic [AW-1:0] bus_in,
    output logic [AW-1:0] addr_q
);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q <= '0;
        end else if (!cs_n && ale) begin
            addr_q <= bus_in;
        end
    end

    // R3
    latch_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!cs_n && ale) |=> (addr_q == $past(bus_in)));

    // R3
    latch_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(!cs_n && ale) |=> $stable(addr_q));

endmodule

// File: rtl/hbus_regfile.sv
module hbus_regfile #(
    parameter int RAW = 4,
    parameter int DW  = 8
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           we,
    input  logic [RAW-1:0] waddr,
    input  logic [DW-1:0]  wdata,
    input  logic [RAW-1:0] raddr,
    output logic [DW-1:0]  rdata
);

    localparam int DEPTH = 1 << RAW;

    logic [DW-1:0] mem [DEPTH];

    generate
        for (genvar gi = 0; gi < DEPTH; gi++) begin : g_word
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    mem[gi] <= '0;
                end else if (we && (waddr == RAW'(gi))) begin
                    mem[gi] <= wdata;
                end
            end
        end
    endgenerate

    assign rdata = mem[raddr];

    // R5
    commit_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
        we |=> (mem[$past(waddr)] == $past(wdata)));

endmodule

// File: rtl/hbus_ctrl.sv
module hbus_ctrl
    import hbus_pkg::*;
#(
    parameter int ACC_CYCLES = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cs_n,
    input  logic wr_n,
    input  logic rd_n,
    output logic start_o,
    output logic wcap_o,
    output logic commit_o,
    output logic rd_load_o,
    output logic rdy_oe_o,
    output logic data_oe_o
);

    localparam int CNT_W = (ACC_CYCLES < 2) ? 1 : $clog2(ACC_CYCLES);
    localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(ACC_CYCLES - 1);

    hb_state_t        state, nxt;
    logic [CNT_W-1:0] cnt;
    logic             wr_act, rd_act, cnt_zero;

    assign wr_act   = !cs_n && !wr_n;
    assign rd_act   = !cs_n && !rd_n;
    assign cnt_zero = (cnt == '0);

    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE: begin
                if (wr_act)      nxt = ST_WR_WAIT;
                else if (rd_act) nxt = ST_RD_WAIT;
            end
            ST_WR_WAIT: begin
                if (!wr_act)        nxt = ST_IDLE;
                else if (cnt_zero)  nxt = ST_WR_HOLD;
            end
            ST_WR_HOLD: begin
                if (!wr_act) nxt = ST_IDLE;
            end
            ST_RD_WAIT: begin
                if (!rd_act)        nxt = ST_IDLE;
                else if (cnt_zero)  nxt = ST_RD_DRIVE;
            end
            ST_RD_DRIVE: begin
                if (!rd_act) nxt = ST_IDLE;
            end
            default: nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            cnt   <= '0;
        end else begin
            state <= nxt;
            if (start_o) begin
                cnt <= CNT_LOAD;
            end else if ((state == ST_WR_WAIT || state == ST_RD_WAIT) && !cnt_zero) begin
                cnt <= cnt - 1'b1;
            end
        end
    end

    always_comb begin
        start_o   = (state == ST_IDLE) && (wr_act || rd_act);
        wcap_o    = wr_act && (state == ST_IDLE || state == ST_WR_WAIT || state == ST_WR_HOLD);
        commit_o  = (state == ST_WR_WAIT || state == ST_WR_HOLD) && !wr_act;
        rd_load_o = (state == ST_RD_WAIT) && rd_act && cnt_zero;
        rdy_oe_o  = (state == ST_WR_WAIT) || (state == ST_RD_WAIT);
        data_oe_o = (state == ST_RD_WAIT) || (state == ST_RD_DRIVE);
    end

    // R2
    cs_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && cs_n) |=> (state == ST_IDLE));

    // R6
    oe_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(data_oe_o) |-> $past(rd_act));

    // R7
    rdy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((state == ST_WR_WAIT || state == ST_RD_WAIT) && !cnt_zero
         && (wr_act || rd_act)) |=> rdy_oe_o);

    // R8
    wr_prio_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && wr_act && rd_act) |=> (state == ST_WR_WAIT));

    // R9
    rd_abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RD_WAIT && !rd_act) |=> (!rdy_oe_o && !data_oe_o));

endmodule

// File: rtl/hbus_slave.sv
module hbus_slave
    import hbus_pkg::*;
#(
    parameter int AW         = 8,
    parameter int DW         = 8,
    parameter int REG_AW     = 4,
    parameter int ACC_CYCLES = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          mux_mode,
    input  logic          cs_n,
    input  logic          ale,
    input  logic          wr_n,
    input  logic          rd_n,
    input  logic [AW-1:0] addr_in,
    input  logic [DW-1:0] data_in,
    output logic [DW-1:0] data_out,
    output logic          data_oe,
    output logic          rdy_o,
    output logic          rdy_oe
);

    logic [AW-1:0] latched_addr, acc_addr_q, start_addr;
    logic [DW-1:0] wdata_q, rdata_q, rf_rdata;
    logic          start, wcap, commit, rd_load;

    hbus_addr_latch #(.AW(AW)) i_latch (
        .clk    (clk),
        .rst_n  (rst_n),
        .cs_n   (cs_n),
        .ale    (ale),
        .bus_in (data_in[AW-1:0]),
        .addr_q (latched_addr)
    );

    hbus_ctrl #(.ACC_CYCLES(ACC_CYCLES)) i_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .cs_n      (cs_n),
        .wr_n      (wr_n),
        .rd_n      (rd_n),
        .start_o   (start),
        .wcap_o    (wcap),
        .commit_o  (commit),
        .rd_load_o (rd_load),
        .rdy_oe_o  (rdy_oe),
        .data_oe_o (data_oe)
    );

    hbus_regfile #(.RAW(REG_AW), .DW(DW)) i_regs (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (commit),
        .waddr (acc_addr_q[REG_AW-1:0]),
        .wdata (wdata_q),
        .raddr (acc_addr_q[REG_AW-1:0]),
        .rdata (rf_rdata)
    );

    always_comb begin
        if (mux_mode) begin
            start_addr = (ale && !cs_n) ? data_in[AW-1:0] : latched_addr;
        end else begin
            start_addr = addr_in;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_addr_q <= '0;
            wdata_q    <= '0;
            rdata_q    <= '0;
        end else begin
            if (start)   acc_addr_q <= start_addr;
            if (wcap)    wdata_q    <= data_in;
            if (rd_load) rdata_q    <= rf_rdata;
        end
    end

    assign data_out = rdata_q;
    assign rdy_o    = 1'b0;

    // R7
    rdy_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rdy_oe |-> !rdy_o);

endmodule

// File: tb/test_hbus_slave.sv
module test_hbus_slave;

    localparam int ACC = 3;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       mux_mode = 1'b0;
    logic       cs_n = 1'b1;
    logic       ale = 1'b0;
    logic       wr_n = 1'b1;
    logic       rd_n = 1'b1;
    logic [7:0] addr_in = '0;
    logic [7:0] data_in = '0;
    logic [7:0] data_out;
    logic       data_oe, rdy_o, rdy_oe;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;
    logic [7:0] model [16];

    always #10 clk = ~clk;

    hbus_slave #(.ACC_CYCLES(ACC)) i_hbus_slave (
        .clk(clk), .rst_n(rst_n), .mux_mode(mux_mode), .cs_n(cs_n), .ale(ale),
        .wr_n(wr_n), .rd_n(rd_n), .addr_in(addr_in), .data_in(data_in),
        .data_out(data_out), .data_oe(data_oe), .rdy_o(rdy_o), .rdy_oe(rdy_oe)
    );

    function automatic logic [7:0] exp_read(input logic [7:0] a);
        return model[a[3:0]];
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            fails++;
            $display("FAIL watchdog actual=%0d expected=<150000", cycles);
            finish_run();
        end
    end

    // Wait out the ready window, counting cycles with ready driven.
    task automatic wait_ready(output int n);
        n = 0;
        @(negedge clk);
        while (rdy_oe && n < 40) begin
            if (rdy_o !== 1'b0) check("R7 rdy value", rdy_o, 0);
            n++;
            @(negedge clk);
        end
    endtask

    task automatic present_addr(input logic mux, input logic [7:0] a);
        mux_mode = mux;
        cs_n = 1'b0;
        if (mux) begin
            ale = 1'b1; data_in = a;
            @(negedge clk);
            ale = 1'b0;
        end else begin
            addr_in = a;
            ale = $urandom_range(0, 1);
            data_in = $urandom_range(0, 255);
        end
    endtask

    task automatic do_write(input logic mux, input logic [7:0] a, input logic [7:0] d);
        int n;
        present_addr(mux, a);
        data_in = d;
        wr_n = 1'b0;
        wait_ready(n);
        check("R7 write ready length", n, ACC);
        wr_n = 1'b1; cs_n = 1'b1; ale = 1'b0;
        @(negedge clk);
        model[a[3:0]] = d;
    endtask

    task automatic do_read(input logic mux, input logic [7:0] a, input string req);
        int n;
        present_addr(mux, a);
        rd_n = 1'b0;
        wait_ready(n);
        check("R7 read ready length", n, ACC);
        check({req, " R6 oe during read"}, data_oe, 1);
        check({req, " R6 read data"}, data_out, exp_read(a));
        rd_n = 1'b1; cs_n = 1'b1; ale = 1'b0;
        @(negedge clk);
        check("R6 oe released", data_oe, 0);
    endtask

    initial begin
        void'($urandom(32'h5eed_1234));
        for (int i = 0; i < 16; i++) model[i] = 8'h00;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        check("R1 data_oe", data_oe, 0);
        check("R1 rdy_oe", rdy_oe, 0);
        for (int i = 0; i < 16; i++) do_read(1'b0, 8'(i), "R1");

        // R4 separate mode, ale toggling ignored
        do_write(1'b0, 8'h05, 8'hA5);
        do_read(1'b0, 8'h05, "R4");

        // R3 multiplexed latch held across cycles
        do_write(1'b1, 8'h0C, 8'h3C);
        do_read(1'b1, 8'h0C, "R3");

        // R5 aliasing of upper address bits
        do_write(1'b0, 8'hF7, 8'h77);
        do_read(1'b0, 8'h07, "R5 alias");

        // R2 strobes with chip select high are ignored
        cs_n = 1'b1; mux_mode = 1'b0; addr_in = 8'h05; data_in = 8'hFF;
        wr_n = 1'b0; rd_n = 1'b0; ale = 1'b1;
        repeat (ACC + 2) begin
            @(negedge clk);
            if (data_oe !== 1'b0 || rdy_oe !== 1'b0) check("R2 no drive", {data_oe, rdy_oe}, 0);
        end
        check("R2 no ready", rdy_oe, 0);
        wr_n = 1'b1; rd_n = 1'b1; ale = 1'b0;
        @(negedge clk);
        do_read(1'b0, 8'h05, "R2");

        // R3 collision: ale high on the cycle the write strobe starts
        do_write(1'b1, 8'h02, 8'h22);    // latch now holds 0x02
        mux_mode = 1'b1; cs_n = 1'b0; ale = 1'b1; data_in = 8'h09; wr_n = 1'b0;
        @(negedge clk);
        ale = 1'b0; data_in = 8'h99;
        check("R3 collision ready", rdy_oe, 1);
        repeat (ACC) @(negedge clk);
        wr_n = 1'b1; cs_n = 1'b1;
        @(negedge clk);
        model[9] = 8'h99;
        do_read(1'b0, 8'h09, "R3 collision new");
        do_read(1'b0, 8'h02, "R3 collision old");

        // R8 both strobes together: write wins, no data drive
        mux_mode = 1'b0; cs_n = 1'b0; addr_in = 8'h0E; data_in = 8'hE1;
        wr_n = 1'b0; rd_n = 1'b0;
        repeat (ACC + 1) begin
            @(negedge clk);
            if (data_oe !== 1'b0) check("R8 no drive", data_oe, 0);
        end
        check("R8 no drive end", data_oe, 0);
        wr_n = 1'b1; rd_n = 1'b1; cs_n = 1'b1;
        @(negedge clk);
        model[14] = 8'hE1;
        do_read(1'b0, 8'h0E, "R8");

        // R9 read aborted while ready low
        mux_mode = 1'b0; cs_n = 1'b0; addr_in = 8'h01; rd_n = 1'b0;
        @(negedge clk);
        check("R9 ready during read", rdy_oe, 1);
        rd_n = 1'b1;
        @(negedge clk);
        check("R9 ready released", rdy_oe, 0);
        check("R9 oe released", data_oe, 0);
        cs_n = 1'b1;
        @(negedge clk);

        // R5 chip select release commits the write
        mux_mode = 1'b0; cs_n = 1'b0; addr_in = 8'h03; data_in = 8'h33; wr_n = 1'b0;
        repeat (ACC + 1) @(negedge clk);
        cs_n = 1'b1;
        @(negedge clk);
        wr_n = 1'b1;
        model[3] = 8'h33;
        do_read(1'b1, 8'h03, "R5 cs release");

        // Random mix of modes, addresses, data
        for (int k = 0; k < 150; k++) begin
            logic m;
            logic [7:0] a, d;
            m = 1'($urandom_range(0, 1));
            a = 8'($urandom_range(0, 255));
            d = 8'($urandom_range(0, 255));
            if ($urandom_range(0, 1) == 1) do_write(m, a, d);
            else do_read(m, a, "R6 random");
        end

        finish_run();
    end

endmodule